// File: doc/BRIEF.md
# Block-Compressed Lagged Branch History Register

This block keeps a compressed global branch history for a front end that delivers up to two fetch blocks per cycle. A fetch block ends at an aligned eight-instruction boundary or at a taken control-flow instruction. Each block contributes at most one history bit, and only if it holds a conditional branch. That bit is the direction of the block's last conditional branch XORed with the half of the block where that branch sits. Earlier branches in the block are known to be not taken, so they add nothing.

The predictor cannot use the outcomes of the three most recent blocks in time. The block therefore holds those three blocks in a short window. A block's bit moves into the exposed history only when three newer blocks have arrived. The window also supplies a few address bits from each of those three blocks, so the predictor can combine the fetch address, the lagged history and the recent path in its index. A restore input reloads the history and the window from a checkpoint in a single cycle. The checkpoint output shows the window state so that it can be saved.

Top module: `blkhist_top`

## Requirements
- R1: After a synchronous reset, `hist_o`, `path_o` and `ckpt_o` are all zero.
- R2: A valid block with `bN_br`=1 carries history bit `bN_dir` XOR `bN_half` (half=1 means the second half). A valid block with `bN_br`=0 carries no bit and its entry bit field reads 0.
- R3: A block with `bN_vld`=0 has no effect: when neither block is valid and restore is low, all outputs hold their values.
- R4: A block's bit enters `hist_o` on the clock edge at which the third newer valid block is accepted, and not earlier.
- R5: `hist_o` holds the newest bit at bit 0. Each inserted bit shifts the vector left by one, and the oldest bit past HLEN is dropped. The vector does not change on an edge where no bit leaves the window.
- R6: When both blocks are valid in one cycle, block 0 is older than block 1. If two bits leave the window on one edge, the older one is shifted in first.
- R7: `path_o[PW-1:0]` holds the path bits of the newest valid block, the next PW bits those of the second newest, and the top PW bits those of the third newest. A slot that has not yet been filled reads zero.
- R8: A `restore` input loads `hist_o` from `rs_hist` and the window from `rs_pipe` on one edge. Blocks presented in the same cycle are ignored.
- R9: Window entry i (0 = newest) sits at `ckpt_o[i*EW +: EW]`, where EW = PW+2. Each entry is {has_bit, bit, path}, with has_bit in the MSB. `rs_pipe` uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| b0_vld | input | 1 | Older fetch block valid |
| b0_br | input | 1 | Older block holds a conditional branch |
| b0_dir | input | 1 | Direction of its last conditional branch |
| b0_half | input | 1 | That branch lies in the second half |
| b0_path | input | PW | Address bits of the older block |
| b1_vld | input | 1 | Younger fetch block valid |
| b1_br | input | 1 | Younger block holds a conditional branch |
| b1_dir | input | 1 | Direction of its last conditional branch |
| b1_half | input | 1 | That branch lies in the second half |
| b1_path | input | PW | Address bits of the younger block |
| restore | input | 1 | Reload state from the checkpoint inputs |
| rs_hist | input | HLEN | Checkpointed history |
| rs_pipe | input | 3*EW | Checkpointed window |
| hist_o | output | HLEN | Three-block-old compressed history |
| path_o | output | 3*PW | Path bits of the three newest blocks |
| ckpt_o | output | 3*EW | Window state for checkpointing |

## Verification
Several events can land on the same edge. Two blocks can be accepted at once, so two entries can leave the window together and two bits enter the history in a fixed order. A restore can also arrive in the same cycle as valid blocks. The bench provokes the first case with dual-block cycles that follow a full window, using bits that differ so that any swapped order shows in `hist_o`. It provokes the second by raising restore while both blocks are valid. In both cases it compares every output against a reference model. That model lists each accepted block as an event and rebuilds the history from all events except the last three.

// File: rtl/bh_pkg.sv
package bh_pkg;
  typedef enum logic [1:0] {PUSH0 = 2'd0, PUSH1 = 2'd1, PUSH2 = 2'd2} push_e;

  function automatic logic blk_bit(input logic dir, input logic half);
    return dir ^ half;
  endfunction
endpackage

// File: rtl/bh_encode.sv
module bh_encode #(
  parameter int PW = 2,
  localparam int EW = PW + 2
) (
  input  logic          br,
  input  logic          dir,
  input  logic          half,
  input  logic [PW-1:0] path,
  output logic [EW-1:0] ent
);
  import bh_pkg::*;
  // entry layout: {has_bit, bit, path}
  always_comb ent = {br, br & blk_bit(dir, half), path};
endmodule

// File: rtl/bh_window.sv
module bh_window #(
  parameter int PW    = 2,
  parameter int DEPTH = 3,
  localparam int EW = PW + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  restore,
  input  logic [DEPTH*EW-1:0]   rs_pipe,
  input  bh_pkg::push_e         push,
  input  logic [EW-1:0]         new_old,
  input  logic [EW-1:0]         new_yng,
  output logic [DEPTH*EW-1:0]   ent,
  output logic [EW-1:0]         leave_a,
  output logic                  leave_a_v,
  output logic [EW-1:0]         leave_b,
  output logic                  leave_b_v
);
  import bh_pkg::*;
  logic [EW-1:0] cur [DEPTH];
  logic [EW-1:0] nxt [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign ent[i*EW +: EW] = cur[i];
      always_comb begin
        nxt[i] = cur[i];
        if (push == PUSH1) begin
          nxt[i] = (i == 0) ? new_yng : cur[(i == 0) ? 0 : i-1];
        end else if (push == PUSH2) begin
          if (i == 0)      nxt[i] = new_yng;
          else if (i == 1) nxt[i] = new_old;
          else             nxt[i] = cur[(i < 2) ? 0 : i-2];
        end
      end
      always_ff @(posedge clk) begin
        if (rst)          cur[i] <= '0;
        else if (restore) cur[i] <= rs_pipe[i*EW +: EW];
        else              cur[i] <= nxt[i];
      end
    end
  endgenerate

  // oldest leaves first
  always_comb begin
    leave_a   = cur[DEPTH-1];
    leave_b   = cur[DEPTH-2];
    leave_a_v = !restore && (push != PUSH0);
    leave_b_v = !restore && (push == PUSH2);
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push == PUSH0 && !restore) |=> $stable(ent));
  // R8
  restore_load_chk: assert property (@(posedge clk) disable iff (rst)
    restore |=> (ent == $past(rs_pipe)));
  // R7
  newest_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (push != PUSH0 && !restore) |=> (ent[EW-1:0] == $past(new_yng)));
endmodule

// File: rtl/bh_shift.sv
module bh_shift #(
  parameter int HLEN = 21,
  parameter int PW   = 2,
  localparam int EW = PW + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restore,
  input  logic [HLEN-1:0] rs_hist,
  input  logic [EW-1:0]   lv_a,
  input  logic            lv_a_v,
  input  logic [EW-1:0]   lv_b,
  input  logic            lv_b_v,
  output logic [HLEN-1:0] hist
);
  logic            in_a, in_b;
  logic [HLEN-1:0] step_a, step_b;

  always_comb begin
    in_a   = lv_a_v && lv_a[EW-1];
    in_b   = lv_b_v && lv_b[EW-1];
    step_a = in_a ? {hist[HLEN-2:0], lv_a[EW-2]} : hist;
    step_b = in_b ? {step_a[HLEN-2:0], lv_b[EW-2]} : step_a;
  end

  always_ff @(posedge clk) begin
    if (rst)          hist <= '0;
    else if (restore) hist <= rs_hist;
    else              hist <= step_b;
  end

  // R5
  hist_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!restore && !in_a && !in_b) |=> $stable(hist));
  // R6
  dual_order_chk: assert property (@(posedge clk) disable iff (rst)
    (!restore && in_a && in_b) |=>
      (hist[1:0] == {$past(lv_a[EW-2]), $past(lv_b[EW-2])}));
  // R8
  restore_hist_chk: assert property (@(posedge clk) disable iff (rst)
    restore |=> (hist == $past(rs_hist)));
endmodule

// File: rtl/blkhist_top.sv
module blkhist_top #(
  parameter int HLEN = 21,
  parameter int PW   = 2,
  localparam int DEPTH = 3,
  localparam int EW    = PW + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                b0_vld,
  input  logic                b0_br,
  input  logic                b0_dir,
  input  logic                b0_half,
  input  logic [PW-1:0]       b0_path,
  input  logic                b1_vld,
  input  logic                b1_br,
  input  logic                b1_dir,
  input  logic                b1_half,
  input  logic [PW-1:0]       b1_path,
  input  logic                restore,
  input  logic [HLEN-1:0]     rs_hist,
  input  logic [DEPTH*EW-1:0] rs_pipe,
  output logic [HLEN-1:0]     hist_o,
  output logic [DEPTH*PW-1:0] path_o,
  output logic [DEPTH*EW-1:0] ckpt_o
);
  import bh_pkg::*;

  logic [1:0]    l_br, l_dir, l_half;
  logic [PW-1:0] l_path [2];
  logic [EW-1:0] l_ent  [2];
  logic [EW-1:0] new_old, new_yng, lv_a, lv_b;
  logic          lv_a_v, lv_b_v;
  push_e         push;

  always_comb begin
    l_br   = {b1_br, b0_br};
    l_dir  = {b1_dir, b0_dir};
    l_half = {b1_half, b0_half};
    l_path[0] = b0_path;
    l_path[1] = b1_path;
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      bh_encode #(.PW(PW)) u_enc (
        .br(l_br[g]), .dir(l_dir[g]), .half(l_half[g]),
        .path(l_path[g]), .ent(l_ent[g]));
    end
  endgenerate

  // compact valid blocks: the younger valid one always lands in slot 0
  always_comb begin
    new_old = l_ent[0];
    new_yng = b1_vld ? l_ent[1] : l_ent[0];
    case ({b1_vld, b0_vld})
      2'b11:         push = PUSH2;
      2'b01, 2'b10:  push = PUSH1;
      default:       push = PUSH0;
    endcase
  end

  bh_window #(.PW(PW), .DEPTH(DEPTH)) u_win (
    .clk(clk), .rst(rst), .restore(restore), .rs_pipe(rs_pipe),
    .push(push), .new_old(new_old), .new_yng(new_yng), .ent(ckpt_o),
    .leave_a(lv_a), .leave_a_v(lv_a_v), .leave_b(lv_b), .leave_b_v(lv_b_v));

  bh_shift #(.HLEN(HLEN), .PW(PW)) u_hist (
    .clk(clk), .rst(rst), .restore(restore), .rs_hist(rs_hist),
    .lv_a(lv_a), .lv_a_v(lv_a_v), .lv_b(lv_b), .lv_b_v(lv_b_v),
    .hist(hist_o));

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_path
      assign path_o[i*PW +: PW] = ckpt_o[i*EW +: PW];
    end
  endgenerate

  // R2
  nobranch_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (b1_vld && !b1_br && !restore) |=> (ckpt_o[EW-1:EW-2] == 2'b00));
endmodule

// File: tb/sim_blkhist_top.sv
`timescale 1ns/1ps
module sim_blkhist_top;
  localparam int HLEN = 21;
  localparam int PW   = 2;
  localparam int EW   = PW + 2;

  logic clk = 0;
  logic rst;
  logic b0_vld, b0_br, b0_dir, b0_half, b1_vld, b1_br, b1_dir, b1_half, restore;
  logic [PW-1:0] b0_path, b1_path;
  logic [HLEN-1:0] rs_hist;
  logic [3*EW-1:0] rs_pipe;
  logic [HLEN-1:0] hist_o;
  logic [3*PW-1:0] path_o;
  logic [3*EW-1:0] ckpt_o;

  int errors = 0;
  int checks = 0;

  // reference model: base history plus list of accepted blocks
  logic [HLEN-1:0] m_base;
  logic            m_hb  [1024];
  logic            m_bit [1024];
  logic [PW-1:0]   m_path[1024];
  int              m_n;

  always #2.5 clk = ~clk;

  blkhist_top #(.HLEN(HLEN), .PW(PW)) u0 (.*);

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [HLEN-1:0] exp_hist();
    logic [HLEN-1:0] h = m_base;
    for (int i = 0; i < m_n - 3; i++)
      if (m_hb[i]) h = {h[HLEN-2:0], m_bit[i]};
    return h;
  endfunction

  function automatic logic [3*EW-1:0] exp_ckpt();
    logic [3*EW-1:0] c = '0;
    for (int j = 0; j < 3; j++) begin
      int k = m_n - 1 - j;
      if (k >= 0) c[j*EW +: EW] = {m_hb[k], m_bit[k], m_path[k]};
    end
    return c;
  endfunction

  function automatic logic [3*PW-1:0] exp_path();
    logic [3*EW-1:0] c = exp_ckpt();
    logic [3*PW-1:0] p;
    for (int j = 0; j < 3; j++) p[j*PW +: PW] = c[j*EW +: PW];
    return p;
  endfunction

  task automatic add_ev(input logic br, input logic dir, input logic half, input logic [PW-1:0] p);
    m_hb[m_n]   = br;
    m_bit[m_n]  = br & (dir ^ half);
    m_path[m_n] = p;
    m_n++;
  endtask

  task automatic chk(input string req);
    checks++;
    if (hist_o !== exp_hist()) begin
      errors++;
      $display("FAIL %s hist: actual=%h expected=%h", req, hist_o, exp_hist());
    end
    checks++;
    if (path_o !== exp_path()) begin
      errors++;
      $display("FAIL %s path: actual=%h expected=%h", req, path_o, exp_path());
    end
    checks++;
    if (ckpt_o !== exp_ckpt()) begin
      errors++;
      $display("FAIL %s ckpt: actual=%h expected=%h", req, ckpt_o, exp_ckpt());
    end
  endtask

  task automatic idle_inputs();
    {b0_vld, b0_br, b0_dir, b0_half, b1_vld, b1_br, b1_dir, b1_half, restore} = '0;
    b0_path = '0; b1_path = '0; rs_hist = '0; rs_pipe = '0;
  endtask

  // one cycle with the given blocks; model updated, outputs checked after edge
  task automatic step(input logic v0, input logic br0, input logic d0, input logic h0, input logic [PW-1:0] p0,
                      input logic v1, input logic br1, input logic d1, input logic h1, input logic [PW-1:0] p1,
                      input string req);
    b0_vld = v0; b0_br = br0; b0_dir = d0; b0_half = h0; b0_path = p0;
    b1_vld = v1; b1_br = br1; b1_dir = d1; b1_half = h1; b1_path = p1;
    @(posedge clk);
    if (v0) add_ev(br0, d0, h0, p0);
    if (v1) add_ev(br1, d1, h1, p1);
    @(negedge clk);
    idle_inputs();
    chk(req);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1;
    @(posedge clk); @(posedge clk);
    m_base = '0; m_n = 0;
    @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1");
  endtask

  task automatic t_single_lag();
    do_reset();
    // branch taken in first half -> 1, taken in second half -> 0
    step(1,1,1,0,2'd1, 0,0,0,0,2'd0, "R2");
    step(1,1,1,1,2'd2, 0,0,0,0,2'd0, "R7");
    step(1,1,0,1,2'd3, 0,0,0,0,2'd0, "R4");
    // first block's bit enters now
    step(1,1,0,0,2'd0, 0,0,0,0,2'd0, "R4");
    step(0,0,0,0,2'd0, 1,1,1,0,2'd1, "R5");
  endtask

  task automatic t_nobranch();
    do_reset();
    step(1,0,1,1,2'd2, 0,0,0,0,2'd0, "R2");
    for (int i = 0; i < 4; i++) step(1,1,1,0,2'(i), 0,0,0,0,2'd0, "R2");
  endtask

  task automatic t_invalid();
    do_reset();
    for (int i = 0; i < 4; i++) step(1,1,i[0],0,2'(i), 0,0,0,0,2'd0, "R3");
    step(0,1,1,0,2'd3, 0,1,1,1,2'd2, "R3");
    step(0,0,0,0,2'd0, 0,0,0,0,2'd0, "R3");
  endtask

  task automatic t_dual();
    do_reset();
    step(1,1,1,0,2'd1, 1,1,0,0,2'd2, "R6");
    step(1,1,1,1,2'd3, 1,1,1,0,2'd0, "R6");
    step(1,1,0,1,2'd2, 1,1,0,0,2'd1, "R6");
    step(1,0,0,0,2'd1, 1,1,1,0,2'd3, "R6");
    step(1,1,1,0,2'd0, 1,0,0,0,2'd2, "R6");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 30; i++)
      step(1,1,i[0]^i[2],i[1],2'(i), 1,1,i[1],i[0],2'(i+1), "R5");
  endtask

  task automatic t_restore();
    logic [3*EW-1:0] rp;
    do_reset();
    for (int i = 0; i < 5; i++) step(1,1,1,0,2'(i), 0,0,0,0,2'd0, "R8");
    rp = {4'b1101, 4'b0010, 4'b1011};
    rs_hist = 21'h0A5C3; rs_pipe = rp; restore = 1;
    b0_vld = 1; b0_br = 1; b0_dir = 1; b1_vld = 1; b1_br = 1; b1_path = 2'd3;
    @(posedge clk);
    m_base = 21'h0A5C3; m_n = 0;
    for (int j = 2; j >= 0; j--) begin
      m_hb[m_n] = rp[j*EW+EW-1]; m_bit[m_n] = rp[j*EW+EW-2];
      m_path[m_n] = rp[j*EW +: PW]; m_n++;
    end
    @(negedge clk);
    idle_inputs();
    chk("R8");
    // window drains in R9 layout order: oldest (entry 2) first
    step(1,1,0,0,2'd0, 0,0,0,0,2'd0, "R9");
    step(1,1,1,0,2'd1, 1,1,1,1,2'd2, "R9");
  endtask

  initial begin
    rst = 1;
    idle_inputs();
    m_base = '0; m_n = 0;
    t_reset();
    t_single_lag();
    t_nobranch();
    t_invalid();
    t_dual();
    t_overflow();
    t_restore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule